// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a small microcontroller between its running state and two sleep depths, and drives the oscillator enable and the per-subsystem enables for the core, watchdog, timer, low-battery detector and brown-out reset. Software requests a sleep depth by writing a byte to a control register. Two bits of that byte are write-only request bits that clear themselves.

The deep sleep stops the oscillator and every subsystem. Only the wakeup-unit input can end it. After that wake the oscillator runs for a fixed settling interval while the core stays stalled, and then the core is released. The light sleep keeps the oscillator, watchdog and timer running. It ends on either a timer overflow or the wakeup input, and the core restarts on the next cycle.

Every wake raises a flag that tells software it must write 00h to the power-mode-clear register. The flag drops when that write happens. Wake inputs are sampled on the clock. A wake that coincides with the entry write is held, so the block enters the mode and leaves it again one cycle later.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset `mode_state` is 0 (run), all six enables are 1, and `clr_pending` is 0. Mode codes are 0 run, 1 deep sleep, 2 settling and 3 light sleep.
- R2: In run, a control write with bit 0 set gives mode 1 on the next cycle. If bit 0 is clear and bit 1 is set, the write gives mode 3. A write with both bits clear leaves the mode at 0.
- R3: If bits 0 and 1 are set in the same write, deep sleep (mode 1) is selected.
- R4: In mode 1 all six enables are 0.
- R5: In mode 1 a timer overflow has no effect and the mode stays 1. A control write made while not in run is ignored.
- R6: In mode 1, `wake_miw` high at a clock edge gives mode 2 on the next cycle. In mode 2 `osc_en` is 1 and all other enables are 0.
- R7: Mode 2 lasts exactly SETTLE_CYC cycles (64 by default) and is then followed by mode 0.
- R8: In mode 3, `osc_en`, `wdog_en` and `tmr_en` are 1, and `core_en`, `lbd_en` and `bor_en` are 0.
- R9: In mode 3, `tmr_ovf` or `wake_miw` high at an edge gives mode 0 on the next cycle, with `core_en` at 1.
- R10: Each wake sets `clr_pending` on the cycle the block leaves sleep. The flag stays set until a power-mode-clear write with data 00h, and drops on the next cycle. A write with any other value does not clear it.
- R11: A wake input that is high in the same cycle as the entry write makes the block enter the mode and leave it on the following cycle. The request bits do not persist, so after a wake the block stays in run until a new write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data; bit 0 requests deep sleep, bit 1 light sleep |
| pmc_wr | input | 1 | Power-mode-clear register write strobe |
| pmc_wdata | input | 8 | Power-mode-clear write data |
| wake_miw | input | 1 | Wake request from the multi-input wakeup unit |
| tmr_ovf | input | 1 | Overflow pulse from the free-running idle timer |
| osc_en | output | 1 | Oscillator enable |
| core_en | output | 1 | Core clock enable |
| wdog_en | output | 1 | Watchdog enable |
| tmr_en | output | 1 | Timer enable |
| lbd_en | output | 1 | Low-battery detector enable |
| bor_en | output | 1 | Brown-out reset enable |
| clr_pending | output | 1 | Wake seen, power-mode-clear write still owed |
| mode_state | output | 2 | Current mode code |

## Verification
The bench counts the settling interval cycle by cycle. A counter that is off by one shows up as 63 or 65 cycles instead of 64. It sends a timer overflow into deep sleep, where a design that wrongly shared the light-sleep exit path would wake early. It writes both request bits together to catch a reversed priority, and it raises the wake input in the same cycle as the entry write, where a design that drops the wake would stay asleep. It also writes a non-zero value to the clear register, which must not drop the pending flag, and then writes 00h, which must.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PM_RUN    = 2'd0,
        PM_HALT   = 2'd1,
        PM_SETTLE = 2'd2,
        PM_IDLE   = 2'd3
    } pmode_t;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_DEEP = 2'd1,
        REQ_LITE = 2'd2
    } req_t;

    typedef struct packed {
        logic osc;
        logic core;
        logic wdog;
        logic tmr;
        logic lbd;
        logic bor;
    } gate_t;

    localparam int DEEP_BIT = 0;
    localparam int LITE_BIT = 1;

    function automatic req_t decode_req(input logic [7:0] d);
        if (d[DEEP_BIT])      return REQ_DEEP;
        else if (d[LITE_BIT]) return REQ_LITE;
        else                  return REQ_NONE;
    endfunction

    function automatic gate_t gates_for(input pmode_t m);
        gate_t g;
        case (m)
            PM_RUN:    g = '{osc: 1'b1, core: 1'b1, wdog: 1'b1, tmr: 1'b1, lbd: 1'b1, bor: 1'b1};
            PM_HALT:   g = '{osc: 1'b0, core: 1'b0, wdog: 1'b0, tmr: 1'b0, lbd: 1'b0, bor: 1'b0};
            PM_SETTLE: g = '{osc: 1'b1, core: 1'b0, wdog: 1'b0, tmr: 1'b0, lbd: 1'b0, bor: 1'b0};
            default:   g = '{osc: 1'b1, core: 1'b0, wdog: 1'b1, tmr: 1'b1, lbd: 1'b0, bor: 1'b0};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/pwr_entry_dec.sv
module pwr_entry_dec
    import pwr_seq_pkg::*;
(
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output req_t       req
);
    logic unused_hi_bits;
    assign unused_hi_bits = ^ctl_wdata[7:2];

    always_comb begin
        req = ctl_wr ? decode_req(ctl_wdata) : REQ_NONE;
    end
endmodule

// File: rtl/pwr_settle_cnt.sv
module pwr_settle_cnt #(
    parameter int SETTLE_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    output logic done
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt <= '0;
        end else if (active && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = active && (cnt == LAST);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  req_t   req,
    input  logic   wake_miw,
    input  logic   tmr_ovf,
    input  logic   settle_done,
    output pmode_t mode,
    output logic   settle_start,
    output logic   exit_evt
);
    pmode_t mode_n;
    logic   held_wake, held_wake_n;

    always_comb begin
        mode_n       = mode;
        held_wake_n  = held_wake;
        settle_start = 1'b0;
        exit_evt     = 1'b0;
        case (mode)
            PM_RUN: begin
                if (req == REQ_DEEP) begin
                    mode_n      = PM_HALT;
                    held_wake_n = wake_miw;
                end else if (req == REQ_LITE) begin
                    mode_n      = PM_IDLE;
                    held_wake_n = wake_miw | tmr_ovf;
                end
            end
            PM_HALT: begin
                if (wake_miw || held_wake) begin
                    mode_n       = PM_SETTLE;
                    held_wake_n  = 1'b0;
                    settle_start = 1'b1;
                    exit_evt     = 1'b1;
                end
            end
            PM_SETTLE: begin
                if (settle_done) mode_n = PM_RUN;
            end
            default: begin
                if (wake_miw || tmr_ovf || held_wake) begin
                    mode_n      = PM_RUN;
                    held_wake_n = 1'b0;
                    exit_evt    = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= PM_RUN;
            held_wake <= 1'b0;
        end else begin
            mode      <= mode_n;
            held_wake <= held_wake_n;
        end
    end
endmodule

// File: rtl/pwr_clr_track.sv
module pwr_clr_track (
    input  logic       clk,
    input  logic       rst,
    input  logic       exit_evt,
    input  logic       pmc_wr,
    input  logic [7:0] pmc_wdata,
    output logic       pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (exit_evt) begin
            pending <= 1'b1;
        end else if (pmc_wr && pmc_wdata == 8'h00) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic       pmc_wr,
    input  logic [7:0] pmc_wdata,
    input  logic       wake_miw,
    input  logic       tmr_ovf,
    output logic       osc_en,
    output logic       core_en,
    output logic       wdog_en,
    output logic       tmr_en,
    output logic       lbd_en,
    output logic       bor_en,
    output logic       clr_pending,
    output logic [1:0] mode_state
);
    req_t   req;
    pmode_t mode;
    logic   settle_start, settle_done, exit_evt;
    gate_t  gates;

    pwr_entry_dec u_dec (
        .ctl_wr   (ctl_wr),
        .ctl_wdata(ctl_wdata),
        .req      (req)
    );

    pwr_mode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .wake_miw    (wake_miw),
        .tmr_ovf     (tmr_ovf),
        .settle_done (settle_done),
        .mode        (mode),
        .settle_start(settle_start),
        .exit_evt    (exit_evt)
    );

    pwr_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .start (settle_start),
        .active(mode == PM_SETTLE),
        .done  (settle_done)
    );

    pwr_clr_track u_clr (
        .clk      (clk),
        .rst      (rst),
        .exit_evt (exit_evt),
        .pmc_wr   (pmc_wr),
        .pmc_wdata(pmc_wdata),
        .pending  (clr_pending)
    );

    assign gates      = gates_for(mode);
    assign osc_en     = gates.osc;
    assign core_en    = gates.core;
    assign wdog_en    = gates.wdog;
    assign tmr_en     = gates.tmr;
    assign lbd_en     = gates.lbd;
    assign bor_en     = gates.bor;
    assign mode_state = mode;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int SETTLE_CYC = 64
) (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic [7:0] ctl_wdata,
    input logic       pmc_wr,
    input logic [7:0] pmc_wdata,
    input logic       wake_miw,
    input logic       tmr_ovf,
    input logic       osc_en,
    input logic       core_en,
    input logic       wdog_en,
    input logic       tmr_en,
    input logic       lbd_en,
    input logic       bor_en,
    input logic       clr_pending,
    input logic [1:0] mode_state
);
    int unsigned seen;

    always_ff @(posedge clk) begin
        if (rst || mode_state != 2'd2) seen <= 0;
        else                           seen <= seen + 1;
    end

    AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 2'd0 && ctl_wr && ctl_wdata[0]) |=> mode_state == 2'd1); // R3

    AST_DEEP_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 2'd1) |-> !(osc_en || core_en || wdog_en || tmr_en || lbd_en || bor_en)); // R4

    AST_DEEP_TMR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 2'd1 && $past(mode_state) == 2'd1 && !wake_miw) |=> mode_state == 2'd1); // R5

    AST_DEEP_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 2'd1 && wake_miw) |=> (mode_state == 2'd2 && osc_en && !core_en)); // R6

    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 2'd2) |-> seen < SETTLE_CYC); // R7

    AST_SETTLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 2'd2 && seen == SETTLE_CYC - 1) |=> (mode_state == 2'd0 && core_en)); // R7

    AST_LITE_EXIT: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 2'd3 && (tmr_ovf || wake_miw)) |=> (mode_state == 2'd0 && core_en)); // R9

    AST_LITE_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 2'd3 && (tmr_ovf || wake_miw)) |=> clr_pending); // R10

    AST_PEND_DROP: assert property (@(posedge clk) disable iff (rst)
        (pmc_wr && pmc_wdata == 8'h00 && (mode_state == 2'd0 || mode_state == 2'd2)) |=> !clr_pending); // R10
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .pmc_wr(pmc_wr), .pmc_wdata(pmc_wdata), .wake_miw(wake_miw), .tmr_ovf(tmr_ovf),
    .osc_en(osc_en), .core_en(core_en), .wdog_en(wdog_en), .tmr_en(tmr_en),
    .lbd_en(lbd_en), .bor_en(bor_en), .clr_pending(clr_pending), .mode_state(mode_state)
);

// File: tb/test_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwr_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       ctl_wr, pmc_wr, wake_miw, tmr_ovf;
    logic [7:0] ctl_wdata, pmc_wdata;
    logic       osc_en, core_en, wdog_en, tmr_en, lbd_en, bor_en, clr_pending;
    logic [1:0] mode_state;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwr_seq_ctrl i_pwr_seq_ctrl (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .pmc_wr(pmc_wr), .pmc_wdata(pmc_wdata), .wake_miw(wake_miw), .tmr_ovf(tmr_ovf),
        .osc_en(osc_en), .core_en(core_en), .wdog_en(wdog_en), .tmr_en(tmr_en),
        .lbd_en(lbd_en), .bor_en(bor_en), .clr_pending(clr_pending), .mode_state(mode_state)
    );

    // vector: wr, data[7:0], miw, ovf, expected mode[1:0]
    localparam int NV = 9;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 8'h00, 1'b0, 1'b0, 2'd0},   // R2 empty write stays in run
        {1'b1, 8'h02, 1'b0, 1'b0, 2'd3},   // R2 light sleep
        {1'b0, 8'h00, 1'b0, 1'b0, 2'd3},   // R8 stays asleep
        {1'b0, 8'h00, 1'b0, 1'b1, 2'd0},   // R9 timer wake
        {1'b0, 8'h00, 1'b0, 1'b0, 2'd0},   // R11 no re-entry
        {1'b1, 8'h01, 1'b0, 1'b0, 2'd1},   // R2 deep sleep
        {1'b0, 8'h00, 1'b0, 1'b1, 2'd1},   // R5 timer ignored
        {1'b1, 8'h02, 1'b0, 1'b0, 2'd1},   // R5 write ignored
        {1'b0, 8'h00, 1'b1, 1'b0, 2'd2}    // R6 wake to settle
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_gates(input logic [1:0] m);
        case (m)
            2'd0:    return 6'b111111;
            2'd1:    return 6'b000000;
            2'd2:    return 6'b100000;
            default: return 6'b101100;
        endcase
    endfunction

    task automatic chk_mode(input string req, input logic [1:0] m);
        chk(req, {6'd0, mode_state}, {6'd0, m});
        chk(req, {2'd0, osc_en, core_en, wdog_en, tmr_en, lbd_en, bor_en}, {2'd0, exp_gates(m)});
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        ctl_wr = 0; ctl_wdata = 0; pmc_wr = 0; pmc_wdata = 0; wake_miw = 0; tmr_ovf = 0;
    endtask

    int n;

    initial begin
        rst = 1; ctl_wr = 0; ctl_wdata = 0; pmc_wr = 0; pmc_wdata = 0; wake_miw = 0; tmr_ovf = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk_mode("R1", 2'd0);
        chk("R1", {7'd0, clr_pending}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            ctl_wr = VEC[i][12]; ctl_wdata = VEC[i][11:4];
            wake_miw = VEC[i][3]; tmr_ovf = VEC[i][2];
            step();
            chk_mode($sformatf("R2/R5/R6/R8/R9 vec%0d", i), VEC[i][1:0]);
        end

        // R7 settle length
        n = 0;
        while (mode_state == 2'd2 && n < 200) begin
            n++;
            chk("R6 core stalled", {7'd0, core_en}, 8'd0);
            step();
        end
        chk("R7 settle cycles", 8'(n), 8'd64);
        chk_mode("R7 back to run", 2'd0);

        // R10 pending clear
        chk("R10 set", {7'd0, clr_pending}, 8'd1);
        pmc_wr = 1; pmc_wdata = 8'h05; step();
        chk("R10 nonzero keeps", {7'd0, clr_pending}, 8'd1);
        pmc_wr = 1; pmc_wdata = 8'h00; step();
        chk("R10 cleared", {7'd0, clr_pending}, 8'd0);

        // R3 both bits
        ctl_wr = 1; ctl_wdata = 8'h03; step();
        chk_mode("R3 priority", 2'd1);
        chk_mode("R4 deep gates", 2'd1);

        // R11 wake in entry cycle (deep)
        wake_miw = 1; step();
        chk_mode("R6 wake", 2'd2);
        while (mode_state == 2'd2) step();
        pmc_wr = 1; pmc_wdata = 8'h00; step();

        ctl_wr = 1; ctl_wdata = 8'h02; wake_miw = 1; step();
        chk_mode("R11 enter light", 2'd3);
        step();
        chk_mode("R11 leave light", 2'd0);
        chk("R11 pending", {7'd0, clr_pending}, 8'd1);
        step(); step();
        chk_mode("R11 stays run", 2'd0);

        ctl_wr = 1; ctl_wdata = 8'h01; wake_miw = 1; step();
        chk_mode("R11 enter deep", 2'd1);
        step();
        chk_mode("R11 leave deep", 2'd2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule